// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Internal Wrap

This block turns a stream of pre-encoded parallel words into a serial bit stream. It runs on a single clock at the serial bit rate. An input strobe, `byte_tick`, is high for one cycle in every `WORD_W` cycles and marks the word slots. In a slot cycle the block loads a word into a shift register, least significant bit first. It then emits one bit per clock for `WORD_W` clocks. A word that follows immediately starts in the cycle after the previous word's last bit, so consecutive words have no gap between them. Encoding is the producer's job: words arrive already in line code.

The parallel side is a valid/ready stream. `in_ready` is high only in slot cycles, and a word is taken when `in_valid` and `in_ready` are both high. A producer that misses a slot must hold its word and `in_valid` until the next slot; the block never buffers. A slot that passes with `in_valid` low sends `WORD_W` idle ones.

A plain control pin, `wrap_en`, selects the routing of the serial stream. When it is high, the internal stream goes to the receive-side output `rx_serial` in place of the external line input, and `line_tx` is held at 1. When it is low, `line_tx` carries the stream and `rx_serial` passes `line_rx` through. Changing `wrap_en` changes only the routing and never the shifting.

Top module: `ser_loop_top`

## Requirements
- R1: `in_ready` is high in exactly the cycles where `byte_tick` is high, and a word is accepted only when `in_valid` and `in_ready` are both high at a rising clock edge.
- R2: After a word is accepted at edge k, its bit i (bit 0 is the least significant bit) is presented on the internal serial stream between edges k+i and k+i+1, for i from 0 to `WORD_W`-1.
- R3: With `byte_tick` high every `WORD_W` cycles and a word offered in every slot, the bits of consecutive words follow each other with no gap and no repeat.
- R4: A slot with `in_valid` low sends `WORD_W` bits of logic 1.
- R5: While reset is asserted, and after reset until the first slot, the serial stream is logic 1. Asserting reset in the middle of a word forces the stream to 1 at once.
- R6: While `wrap_en` is high, `line_tx` is logic 1.
- R7: While `wrap_en` is high, `rx_serial` carries the internal serial stream.
- R8: While `wrap_en` is low, `line_tx` carries the internal serial stream and `rx_serial` equals `line_rx`.
- R9: Toggling `wrap_en` in the middle of a word does not disturb the bit sequence. Each bit appears on whichever output the current routing selects.
- R10: `in_valid` and `in_data` are ignored in cycles where `byte_tick` is low, and the word being sent is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_tick | input | 1 | Slot strobe, high one cycle in every `WORD_W` |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Block takes a word this cycle |
| in_data | input | WORD_W | Pre-encoded parallel word, bit 0 sent first |
| wrap_en | input | 1 | 1 routes the stream internally and holds the line high |
| line_rx | input | 1 | External serial receive input |
| line_tx | output | 1 | Serial line output |
| rx_serial | output | 1 | Serial stream delivered to the receiver |

## Verification
A wrong shift-register state shows up on the serial output in the very next bit period. A bad load or a wrong fill value corrupts the bit sequence of that word, or of the idle slot after it, within one word time of `WORD_W` cycles. A wrong routing selection shows at once on `line_tx` or `rx_serial` in the same cycle `wrap_en` changes. Comparing every bit of every slot against the offered word, under both routings and with the routing switched mid-word, exposes each of these states within a single slot.

// File: rtl/ser_loop_pkg.sv
package ser_loop_pkg;
  localparam int unsigned SER_WORD_W = 10;

  typedef enum logic {
    ROUTE_LINE = 1'b0,
    ROUTE_WRAP = 1'b1
  } route_e;
endpackage

// File: rtl/ser_loop_admit.sv
// Slot admission: grants the input stream only in slot cycles and
// substitutes an idle word when the producer has nothing to offer.
module ser_loop_admit #(
  parameter int unsigned WORD_W = ser_loop_pkg::SER_WORD_W
) (
  input  logic              byte_tick,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              load,
  output logic [WORD_W-1:0] load_word
);
  localparam logic [WORD_W-1:0] IDLE_WORD = {WORD_W{1'b1}};

  logic take;

  always_comb begin
    in_ready  = byte_tick;
    take      = in_valid && byte_tick;
    load      = byte_tick;
    load_word = take ? in_data : IDLE_WORD;
  end
endmodule

// File: rtl/ser_loop_shift.sv
// Right-shifting serializer: LSB leaves first, ones fill from the top.
module ser_loop_shift #(
  parameter int unsigned WORD_W = ser_loop_pkg::SER_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  output logic              ser_bit
);
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= {WORD_W{1'b1}};
    end else if (load) begin
      shreg_q <= load_word;
    end else begin
      shreg_q <= {1'b1, shreg_q[WORD_W-1:1]};
    end
  end

  assign ser_bit = shreg_q[0];
endmodule

// File: rtl/ser_loop_route.sv
// Routing of the serial stream between line and internal wrap path.
module ser_loop_route
  import ser_loop_pkg::*;
(
  input  logic wrap_en,
  input  logic ser_bit,
  input  logic line_rx,
  output logic line_tx,
  output logic rx_serial
);
  route_e mode;

  always_comb begin
    mode = route_e'(wrap_en);
    unique case (mode)
      ROUTE_WRAP: begin
        line_tx   = 1'b1;
        rx_serial = ser_bit;
      end
      default: begin
        line_tx   = ser_bit;
        rx_serial = line_rx;
      end
    endcase
  end
endmodule

// File: rtl/ser_loop_top.sv
module ser_loop_top #(
  parameter int unsigned WORD_W = ser_loop_pkg::SER_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              wrap_en,
  input  logic              line_rx,
  output logic              line_tx,
  output logic              rx_serial
);
  logic              load;
  logic [WORD_W-1:0] load_word;
  logic              ser_bit;

  ser_loop_admit #(.WORD_W(WORD_W)) u_admit (
    .byte_tick (byte_tick),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .load      (load),
    .load_word (load_word)
  );

  ser_loop_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .ser_bit   (ser_bit)
  );

  ser_loop_route u_route (
    .wrap_en   (wrap_en),
    .ser_bit   (ser_bit),
    .line_rx   (line_rx),
    .line_tx   (line_tx),
    .rx_serial (rx_serial)
  );
endmodule

// File: rtl/ser_loop_chk.sv
module ser_loop_chk #(
  parameter int unsigned WORD_W = ser_loop_pkg::SER_WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_tick,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              wrap_en,
  input logic              line_rx,
  input logic              line_tx,
  input logic              rx_serial
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WORD_W);

  logic             armed;
  logic [CNT_W-1:0] since_load;
  logic             stream;

  assign stream = wrap_en ? rx_serial : line_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      since_load <= CNT_END;
    end else begin
      armed <= 1'b1;
      if (byte_tick) since_load <= '0;
      else if (since_load != CNT_END) since_load <= since_load + 1'b1;
    end
  end

  // R1
  ready_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == byte_tick);

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && in_ready)) |-> (stream == $past(in_data[0])));

  // R4
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(byte_tick && !in_valid)) |-> stream);

  // R5
  drained_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_load == CNT_END) |-> stream);

  // R6
  wrap_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_en |-> line_tx);

  // R8
  rx_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_en |-> (rx_serial == line_rx));
endmodule

bind ser_loop_top ser_loop_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_tick (byte_tick),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .wrap_en   (wrap_en),
  .line_rx   (line_rx),
  .line_tx   (line_tx),
  .rx_serial (rx_serial)
);

// File: tb/sim_ser_loop_top.sv
`timescale 1ns/1ps
module sim_ser_loop_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         byte_tick = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         wrap_en = 1'b0;
  logic         line_rx = 1'b0;
  logic         in_ready;
  logic         line_tx;
  logic         rx_serial;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ser_loop_top #(.WORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .wrap_en(wrap_en),
    .line_rx(line_rx), .line_tx(line_tx), .rx_serial(rx_serial)
  );

  // {wrap, valid, data[9:0], line_rx pattern[9:0]}
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b1, 10'b0011111010, 10'b0000000000},
    {1'b0, 1'b1, 10'b1100000101, 10'b1111111111},
    {1'b0, 1'b0, 10'b0000000000, 10'b1010101010},
    {1'b0, 1'b1, 10'b0000000000, 10'b0101010101},
    {1'b1, 1'b1, 10'b1010011001, 10'b0000000000},
    {1'b1, 1'b0, 10'b0000000000, 10'b0000000000},
    {1'b1, 1'b1, 10'b0000000001, 10'b1111111111},
    {1'b0, 1'b1, 10'b1000000000, 10'b1100110011}
  };

  task automatic check(input bit ok, input string req, input string detail);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  // Starts at a negedge; ends at the negedge showing the last bit.
  task automatic run_slot(input logic w, input logic v, input logic [W-1:0] d,
                          input logic [W-1:0] rp, input int toggle_at,
                          input bit poke, input string req);
    logic         wnow;
    logic [W-1:0] act_l, exp_l, act_r, exp_r;
    int           rdy_bad;
    logic         eb;
    wnow = w;
    rdy_bad = 0;
    byte_tick = 1'b1; in_valid = v; in_data = d; wrap_en = w; line_rx = rp[0];
    #1;
    if (in_ready !== 1'b1) rdy_bad++;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      byte_tick = 1'b0; in_valid = 1'b0;
      if (toggle_at == i) wnow = ~wnow;
      wrap_en = wnow;
      line_rx = rp[i];
      if (poke && i >= 3 && i <= 5) begin
        in_valid = 1'b1; in_data = ~d;
      end
      #1;
      if (in_ready !== 1'b0) rdy_bad++;
      eb = v ? d[i] : 1'b1;
      exp_l[i] = wnow ? 1'b1 : eb;
      exp_r[i] = wnow ? eb : rp[i];
      act_l[i] = line_tx;
      act_r[i] = rx_serial;
    end
    check(act_l === exp_l && act_r === exp_r, req,
          $sformatf("line_tx %b exp %b, rx_serial %b exp %b", act_l, exp_l, act_r, exp_r));
    check(rdy_bad == 0, "R1", $sformatf("in_ready wrong in %0d cycles, exp 0", rdy_bad));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R5: reset state
    repeat (3) @(negedge clk);
    #1;
    check(line_tx === 1'b1 && rx_serial === line_rx, "R5",
          $sformatf("in reset line_tx %b exp 1", line_tx));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    line_rx = 1'b0;
    #1;
    check(line_tx === 1'b1, "R5", $sformatf("before first slot line_tx %b exp 1", line_tx));
    check(rx_serial === 1'b0, "R8", $sformatf("rx_serial %b exp line_rx 0", rx_serial));

    // Table: back-to-back slots (R2 R3 R4 R6 R7 R8)
    for (int k = 0; k < NV; k++) begin
      run_slot(VEC[k][21], VEC[k][20], VEC[k][19:10], VEC[k][9:0], -1, 1'b0,
               "R2 R3 R4 R6 R7 R8 table");
    end

    // R9: wrap toggled mid-word, both directions
    run_slot(1'b0, 1'b1, 10'b0110010111, 10'b0011001100, 4, 1'b0, "R9 wrap on mid-word");
    run_slot(1'b1, 1'b1, 10'b1001101000, 10'b1111000011, 6, 1'b0, "R9 wrap off mid-word");

    // R10: valid with other data outside the slot
    run_slot(1'b0, 1'b1, 10'b0101100110, 10'b0000000000, -1, 1'b1, "R10 off-slot valid");
    run_slot(1'b1, 1'b1, 10'b0000011111, 10'b0000000000, -1, 1'b1, "R10 off-slot valid wrap");

    // R4: drain with no further slot, stream returns to 1
    wrap_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(line_tx === 1'b1, "R4", $sformatf("after drain line_tx %b exp 1", line_tx));

    // R5: reset in the middle of a zero word
    byte_tick = 1'b1; in_valid = 1'b1; in_data = '0;
    @(negedge clk);
    byte_tick = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    #1;
    check(line_tx === 1'b0, "R2", $sformatf("zero word line_tx %b exp 0", line_tx));
    rst_n = 1'b0;
    #1;
    check(line_tx === 1'b1, "R5", $sformatf("mid-word reset line_tx %b exp 1", line_tx));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(line_tx === 1'b1, "R5", $sformatf("after mid-word reset line_tx %b exp 1", line_tx));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule